// File: doc/BRIEF.md
# Three-Wire Serial Register Master

This block drives a three-wire serial link to a register-based slave. The link has an active-high chip select, a clock that only the master drives, and one data line that both ends share. The host loads a 16-bit command word in one cycle. The word packs a 7-bit register address in bits 15:9, a direction flag in bit 8 (0 = write, 1 = read) and a data byte in bits 7:0. The block then runs the whole frame by itself and sends it most significant bit first.

For a write frame the master drives all sixteen bits. For a read frame it drives the address and the direction flag, and then releases the data line for the last eight bit periods. During those periods it samples the byte that the slave returns. A three-bit rate field sets the serial clock. Rate value n gives a serial period of 2^(n+1) core cycles, so each half period lasts 2^n core cycles. The serial clock idles low.

Chip select wraps every frame with a half-period lead before the first rising edge and a half-period tail after the last falling edge. The data line changes and is sampled only on falling edges. A frame therefore takes 33 half periods. The block reports progress through a busy level and a one-cycle completion pulse.

Top module: `tri_wire_master`

## Requirements
- R1: The serial bits of a frame equal the command word, most significant bit first: address in bits 15:9, direction flag in bit 8, data in bits 7:0.
- R2: Chip select is low when idle. It rises with the frame and stays high for exactly one half period (2^n core cycles) before the first rising edge of the serial clock. The serial clock is high only while chip select is high.
- R3: The master changes its driven data only at falling edges of the serial clock, so the driven data is stable while the clock is high.
- R4: In a read frame (bit 8 = 1) the master drives the line for the first 8 bit periods and releases it (output enable low) for the last 8. It samples the returned bits on falling edges, MSB first, and presents the byte on the read-data output when the frame ends.
- R5: With rate field n, every high phase of the serial clock lasts 2^n core cycles.
- R6: A command write accepted while the block is enabled and idle raises busy and chip select in the next cycle. Busy stays high for exactly 33·2^n core cycles.
- R7: A command write while busy is ignored. No extra frame is sent, and the frame in flight completes unchanged.
- R8: While the enable input is low, a command write is ignored: busy and chip select stay low.
- R9: A one-cycle completion pulse appears in the first cycle with busy low after a frame. A write frame leaves the read-data output unchanged. A command presented in the completion cycle is accepted.
- R10: The serial clock and the data output enable are low whenever chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Permits new frames to start |
| clkSel | input | 3 | Rate field n; half period = 2^n core cycles, latched at frame start |
| cmdWrite | input | 1 | One-cycle strobe that loads the command word |
| cmdWord | input | 16 | Address[15:9], direction[8] (1 = read), data[7:0] |
| busy | output | 1 | High while a frame is in progress |
| done | output | 1 | One-cycle pulse when a frame completes |
| rdData | output | 8 | Byte captured by the last read frame |
| sCs | output | 1 | Serial chip select, active high |
| sClk | output | 1 | Serial clock, idles low |
| sDataOut | output | 1 | Value the master drives onto the data line |
| sDataOe | output | 1 | Output enable for the data line pad |
| sDataIn | input | 1 | Value sensed on the data line |

## Verification
The completion pulse of one frame and the acceptance of the next command can fall in the same core cycle. Busy is already low in that cycle, so a command presented then must start a new frame. The driver waits for the completion pulse and immediately presents the next command in that cycle. The scoreboard then requires the new frame to show up at the slave model with the full busy length and correct content, while the previous frame's read byte has already been scored against its own entry. A second overlap is a command written while a frame is in flight. It is judged by the queue ending empty and by a later read of the targeted register returning its untouched value.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_TAIL
  } twState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // take command word
    logic shift;     // advance outgoing bit at falling edge
    logic sample;    // capture an incoming bit at falling edge
    logic relDrive;  // stop driving the data line
    logic finish;    // frame complete
  } twStrobe_t;
endpackage

// File: rtl/tw_ctrl.sv
module tw_ctrl
  import tw_pkg::*;
#(
  parameter int SEL_W   = 3,
  parameter int FRAME_W = 16,
  parameter int DATA_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [SEL_W-1:0] clkSel,
  input  logic             cmdWrite,
  input  logic             cmdRead,
  output twStrobe_t        strobe,
  output logic             sCs,
  output logic             sClk,
  output logic             busy,
  output logic             done
);
  localparam int CNT_W      = 1 << SEL_W;
  localparam int BIT_W      = $clog2(FRAME_W);
  localparam int LAST_BIT   = FRAME_W - 1;
  localparam int RELEASE_AT = FRAME_W - DATA_W - 1;

  twState_t         st, stNext;
  logic [CNT_W-1:0] halfCnt;
  logic [CNT_W-1:0] halfMax;
  logic [SEL_W-1:0] selReg;
  logic [BIT_W-1:0] bitCnt;
  logic             readMode;
  logic             tick;

  assign halfMax = (CNT_W'(1) << selReg) - CNT_W'(1);
  assign tick    = (halfCnt == halfMax);

  always_comb begin
    stNext = st;
    strobe = '0;
    unique case (st)
      ST_IDLE: begin
        if (enable && cmdWrite) begin
          stNext      = ST_SETUP;
          strobe.load = 1'b1;
        end
      end
      ST_SETUP: if (tick) stNext = ST_HIGH;
      ST_HIGH: begin
        if (tick) begin
          strobe.shift    = (bitCnt != BIT_W'(LAST_BIT));
          strobe.sample   = readMode && (bitCnt > BIT_W'(RELEASE_AT));
          strobe.relDrive = readMode && (bitCnt == BIT_W'(RELEASE_AT));
          stNext          = (bitCnt == BIT_W'(LAST_BIT)) ? ST_TAIL : ST_LOW;
        end
      end
      ST_LOW: if (tick) stNext = ST_HIGH;
      ST_TAIL: begin
        if (tick) begin
          stNext        = ST_IDLE;
          strobe.finish = 1'b1;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      halfCnt  <= '0;
      selReg   <= '0;
      bitCnt   <= '0;
      readMode <= 1'b0;
      done     <= 1'b0;
    end else begin
      st      <= stNext;
      halfCnt <= (st != stNext || st == ST_IDLE) ? '0 : halfCnt + CNT_W'(1);
      done    <= strobe.finish;
      if (strobe.load) begin
        selReg   <= clkSel;
        readMode <= cmdRead;
        bitCnt   <= '0;
      end else if (st == ST_HIGH && tick) begin
        bitCnt <= bitCnt + BIT_W'(1);
      end
    end
  end

  assign sCs  = (st != ST_IDLE);
  assign sClk = (st == ST_HIGH);
  assign busy = sCs;
endmodule

// File: rtl/tw_dpath.sv
module tw_dpath
  import tw_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  twStrobe_t          strobe,
  input  logic [FRAME_W-1:0] cmdWord,
  input  logic               sDataIn,
  output logic               sDataOut,
  output logic               sDataOe,
  output logic [DATA_W-1:0]  rdData
);
  localparam int RW_POS = DATA_W;

  logic [FRAME_W-1:0] shiftReg;
  logic [DATA_W-1:0]  capReg;
  logic               oeReg;
  logic               isRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      capReg   <= '0;
      oeReg    <= 1'b0;
      isRead   <= 1'b0;
      rdData   <= '0;
    end else begin
      if (strobe.load) begin
        shiftReg <= cmdWord;
        isRead   <= cmdWord[RW_POS];
        oeReg    <= 1'b1;
      end else if (strobe.shift) begin
        shiftReg <= {shiftReg[FRAME_W-2:0], 1'b0};
      end
      if (strobe.sample) capReg <= {capReg[DATA_W-2:0], sDataIn};
      if (strobe.relDrive || strobe.finish) oeReg <= 1'b0;
      if (strobe.finish && isRead) rdData <= capReg;
    end
  end

  assign sDataOut = shiftReg[FRAME_W-1];
  assign sDataOe  = oeReg;
endmodule

// File: rtl/tri_wire_master.sv
module tri_wire_master
  import tw_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3,
  localparam int FRAME_W = ADDR_W + 1 + DATA_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [SEL_W-1:0]   clkSel,
  input  logic               cmdWrite,
  input  logic [FRAME_W-1:0] cmdWord,
  output logic               busy,
  output logic               done,
  output logic [DATA_W-1:0]  rdData,
  output logic               sCs,
  output logic               sClk,
  output logic               sDataOut,
  output logic               sDataOe,
  input  logic               sDataIn
);
  twStrobe_t strobe;

  tw_ctrl #(.SEL_W(SEL_W), .FRAME_W(FRAME_W), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .clkSel(clkSel),
    .cmdWrite(cmdWrite), .cmdRead(cmdWord[DATA_W]), .strobe(strobe),
    .sCs(sCs), .sClk(sClk), .busy(busy), .done(done)
  );

  tw_dpath #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdWord(cmdWord),
    .sDataIn(sDataIn), .sDataOut(sDataOut), .sDataOe(sDataOe),
    .rdData(rdData)
  );
endmodule

// File: rtl/tri_wire_master_chk.sv
module tri_wire_master_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic cmdWrite,
  input logic busy,
  input logic done,
  input logic sCs,
  input logic sClk,
  input logic sDataOut,
  input logic sDataOe
);
  assert_clk_inside_cs_R2: assert property (@(posedge clk) disable iff (!rstN)
    sClk |-> sCs);
  assert_lead_before_edge_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sClk) |-> $past(sCs));
  assert_data_still_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sClk && $past(sClk) && sDataOe && $past(sDataOe)) |-> $stable(sDataOut));
  assert_start_next_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && enable && !busy) |=> (busy && sCs));
  assert_busy_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && busy && sClk) |=> busy);
  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !busy) |=> !busy);
  assert_done_on_fall_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !sCs |-> (!sClk && !sDataOe));
endmodule

bind tri_wire_master tri_wire_master_chk chk_i (
  .clk(clk), .rstN(rstN), .enable(enable), .cmdWrite(cmdWrite),
  .busy(busy), .done(done), .sCs(sCs), .sClk(sClk),
  .sDataOut(sDataOut), .sDataOe(sDataOe)
);

// File: tb/tri_wire_master_tb_top.sv
`timescale 1ns/1ps
module tri_wire_master_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        enable;
  logic [2:0]  clkSel;
  logic        cmdWrite;
  logic [15:0] cmdWord;
  logic        busy, done, sCs, sClk, sDataOut, sDataOe;
  logic [7:0]  rdData;
  logic        sDataIn = 1'b0;

  always #2 clk = ~clk;

  tri_wire_master dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .clkSel(clkSel),
    .cmdWrite(cmdWrite), .cmdWord(cmdWord), .busy(busy), .done(done),
    .rdData(rdData), .sCs(sCs), .sClk(sClk), .sDataOut(sDataOut),
    .sDataOe(sDataOe), .sDataIn(sDataIn)
  );

  int vectors = 0;
  int miscompares = 0;

  typedef struct {
    logic [15:0] word;
    logic [7:0]  rd;
    int          sel;
  } expItem_t;

  expItem_t    expQ[$];
  logic [15:0] obsQ[$];
  logic [7:0]  slvMem[128];
  logic [7:0]  shadow[128];
  logic [7:0]  holdRd = 8'h00;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // slave model: samples master bits and drives replies on rising edges
  int          slvPos = 0;
  logic [7:0]  slvCmd;
  logic [7:0]  slvData;
  logic        slvRead;
  logic [6:0]  slvAddr;

  always @(posedge sCs) slvPos = 0;

  always @(posedge sClk) begin
    if (slvPos < 8) begin
      slvCmd = {slvCmd[6:0], sDataOut};
      check(sDataOe == 1'b1, "R4", "master drives command bit", sDataOe, 1);
      if (slvPos == 7) begin
        slvRead = slvCmd[0];
        slvAddr = slvCmd[7:1];
      end
    end else begin
      if (slvRead) begin
        sDataIn = slvMem[slvAddr][15-slvPos];
        check(sDataOe == 1'b0, "R4", "line released for data bit", sDataOe, 0);
      end else begin
        slvData = {slvData[6:0], sDataOut};
      end
    end
    slvPos++;
    if (slvPos == 16) begin
      if (slvRead) obsQ.push_back({slvCmd, slvMem[slvAddr]});
      else begin
        slvMem[slvAddr] = slvData;
        obsQ.push_back({slvCmd, slvData});
      end
    end
  end

  // monitor / scoreboard
  int   busyCnt = 0;
  int   highCnt = 0;
  int   setupCnt = 0;
  bit   seenClk = 0;
  logic prevClk = 0, prevOe = 0, prevOut = 0;

  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      int curSel;
      curSel = (expQ.size() > 0) ? expQ[0].sel : 0;
      if (busy) busyCnt++;
      if (sClk) highCnt++;
      else if (highCnt != 0) begin
        check(highCnt == (1 << curSel), "R5", "clock high width", highCnt, 1 << curSel);
        highCnt = 0;
      end
      if (!sCs) begin
        setupCnt = 0;
        seenClk  = 0;
        check(!sClk && !sDataOe, "R10", "idle clock and enable", {sClk, sDataOe}, 0);
      end else if (!seenClk) begin
        if (sClk) begin
          check(setupCnt == (1 << curSel), "R2", "select lead time", setupCnt, 1 << curSel);
          seenClk = 1;
        end else setupCnt++;
      end
      if (sClk && prevClk && sDataOe && prevOe)
        check(sDataOut == prevOut, "R3", "data stable while clock high", sDataOut, prevOut);
      prevClk = sClk; prevOe = sDataOe; prevOut = sDataOut;
      if (done) begin
        expItem_t e;
        logic [15:0] o;
        check(expQ.size() > 0, "R7", "unexpected completion", expQ.size(), 1);
        if (expQ.size() > 0) begin
          e = expQ.pop_front();
          check(busyCnt == 33 * (1 << e.sel), "R6", "busy length", busyCnt, 33 * (1 << e.sel));
          check(obsQ.size() > 0, "R1", "frame seen by slave", obsQ.size(), 1);
          if (obsQ.size() > 0) begin
            o = obsQ.pop_front();
            check(o == e.word, "R1", "frame contents", o, e.word);
          end
          check(rdData == e.rd, e.word[8] ? "R4" : "R9", "read data output", rdData, e.rd);
          check(!busy, "R9", "busy low at completion", busy, 0);
        end
        busyCnt = 0;
      end
    end
  end

  task automatic sendCmd(input int sel, input logic [6:0] a, input logic rw,
                         input logic [7:0] d);
    expItem_t e;
    e.sel = sel;
    if (rw) begin
      e.word = {a, 1'b1, shadow[a]};
      e.rd   = shadow[a];
      holdRd = shadow[a];
    end else begin
      e.word    = {a, 1'b0, d};
      shadow[a] = d;
      e.rd      = holdRd;
    end
    expQ.push_back(e);
    clkSel   = 3'(sel);
    cmdWord  = {a, rw, d};
    cmdWrite = 1'b1;
    @(negedge clk);
    cmdWrite = 1'b0;
    check(busy && sCs, "R6", "busy and select after command", {busy, sCs}, 2'b11);
  endtask

  task automatic waitDone;
    while (!done) @(negedge clk);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    summary();
  end

  initial begin
    for (int i = 0; i < 128; i++) begin
      slvMem[i] = 8'(i * 7 + 3);
      shadow[i] = 8'(i * 7 + 3);
    end
    rstN = 1'b0; enable = 1'b0; clkSel = 3'd0; cmdWrite = 1'b0; cmdWord = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done, "R6", "reset busy/done", {busy, done}, 0);
    check(!sCs, "R2", "reset select low", sCs, 0);
    check(!sClk && !sDataOe, "R10", "reset clock/enable", {sClk, sDataOe}, 0);
    check(rdData == 8'h00, "R4", "reset read data", rdData, 0);

    // R8: disabled block ignores command
    cmdWord = 16'hA4_55; cmdWrite = 1'b1;
    @(negedge clk);
    cmdWrite = 1'b0;
    for (int k = 0; k < 5; k++) begin
      check(!busy && !sCs, "R8", "disabled ignores command", {busy, sCs}, 0);
      @(negedge clk);
    end

    enable = 1'b1;
    sendCmd(0, 7'h12, 1'b0, 8'hA5); waitDone();
    sendCmd(1, 7'h12, 1'b1, 8'h00); waitDone();
    sendCmd(2, 7'h7F, 1'b1, 8'h00); waitDone();
    sendCmd(0, 7'h00, 1'b0, 8'h3C); waitDone();
    sendCmd(0, 7'h00, 1'b1, 8'h00); waitDone();

    // R7: command during a frame
    sendCmd(3, 7'h05, 1'b0, 8'h11);
    repeat (20) @(negedge clk);
    cmdWord = {7'h33, 1'b0, 8'hEE}; cmdWrite = 1'b1;
    @(negedge clk);
    cmdWrite = 1'b0;
    check(busy, "R7", "frame continues after ignored command", busy, 1);
    waitDone();
    // back-to-back: next command in the completion cycle (R9)
    sendCmd(1, 7'h05, 1'b1, 8'h00); waitDone();
    sendCmd(0, 7'h33, 1'b1, 8'h00); waitDone();
    sendCmd(0, 7'h40, 1'b0, 8'h81); waitDone();
    sendCmd(2, 7'h40, 1'b1, 8'h00); waitDone();
    sendCmd(0, 7'h41, 1'b0, 8'h7E); waitDone();
    repeat (4) @(negedge clk);
    check(!sCs && !sClk, "R10", "idle after frames", {sCs, sClk}, 0);
    check(expQ.size() == 0, "R7", "no pending expected frames", expQ.size(), 0);
    check(obsQ.size() == 0, "R7", "no extra frames at slave", obsQ.size(), 0);
    summary();
  end
endmodule